// File: doc/BRIEF.md
# Exception Vector Entry Unit

This block sequences entry into and exit from the privileged trap handler of a 64-bit processor. Each cycle it accepts a fault code, the PC of the instruction that raised it, and a return-from-trap request. Bit 0 of the PC marks privileged mode. When a fault is presented, the unit looks up the handler offset for that fault. It adds the offset to a programmable vector base and issues a redirect holding the handler PC and the PC after it. It updates the saved return address and, when the trap comes from unprivileged code, pulses a strobe that switches to the shadow register bank.

A return-from-trap in privileged mode redirects fetch to the saved return address and raises a check-interrupts pulse. It also pulses a bank-exit strobe when the saved address lies outside privileged mode. A return-from-trap attempted in unprivileged mode becomes an unimplemented-opcode trap. An arithmetic fault is not vectored. It raises an unsupported-trap error instead.

All results are registered. Inputs sampled at one rising edge appear on the outputs after that edge and last exactly one cycle. The saved return address is a register whose value is always visible on the outputs.

Top module: `trap_entry_unit`

## Requirements
- R1: After a synchronous active-low reset, redir_vld, shadow_enter, shadow_exit, chk_intr and arith_err are 0 and saved_pc is 0. The vector base equals the parameter VBASE_RST (default 0x4000).
- R2: Fault codes map to handler offsets as follows. 1 (reset) maps to 0x0001, 2 (machine check) to 0x0401 and 4 (interrupt) to 0x0101. 5 (native data TLB miss) maps to 0x0201 and 6 (privileged data TLB miss) to 0x0281. 7 (alignment) maps to 0x0301. Both 8 (data TLB fault) and 9 (data access violation) map to 0x0381. Both 10 (instruction TLB miss) and 11 (instruction TLB fault) map to 0x0181. 12 (instruction access violation) maps to 0x0081 and 13 (unimplemented opcode) to 0x0481. 14 (FP disabled) maps to 0x0581, 15 (privileged call) to 0x2001 and 16 (integer overflow) to 0x0501.
- R3: For a vectored fault sampled at an edge, the outputs after that edge show redir_vld=1, redir_pc = vector base + offset and redir_npc = redir_pc + 4, for one cycle only.
- R4: A vectored fault other than the cases in R5 and R6 writes cur_pc into saved_pc.
- R5: Privileged call (15) and integer overflow (16) are in the arithmetic class and write cur_pc + 4 into saved_pc.
- R6: An interrupt (4) taken while cur_pc[0]=1 leaves saved_pc unchanged. When cur_pc[0]=0, it writes cur_pc.
- R7: shadow_enter pulses with a trap redirect exactly when cur_pc[0] was 0.
- R8: When rfe_req is set with cur_pc[0]=1 and no fault, the unit redirects to redir_pc = saved_pc, with redir_npc = saved_pc + 4, and pulses chk_intr. It pulses shadow_exit when saved_pc[0]=0.
- R9: When rfe_req is set with cur_pc[0]=0, the unit behaves as fault 13: it vectors to base + 0x0481, saves cur_pc and pulses shadow_enter, with chk_intr = 0.
- R10: Fault code 3 (arithmetic) pulses arith_err for one cycle. It produces no redirect and leaves saved_pc unchanged.
- R11: Fault code 0 and the unused codes 17 to 31 with no return request change nothing: there is no redirect, no strobe, no error, and saved_pc stays the same.
- R12: A write with vb_we loads vb_wdata into the vector base at the edge. A trap sampled at the same edge still uses the old base.
- R13: A fault presented together with rfe_req wins. The return request is dropped, so there is no chk_intr and no shadow_exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_code | input | 5 | Fault presented this cycle, 0 = none |
| cur_pc | input | 64 | PC of the faulting or returning instruction; bit 0 = privileged |
| rfe_req | input | 1 | Return-from-trap request |
| vb_we | input | 1 | Vector base write enable |
| vb_wdata | input | 64 | Vector base write data |
| redir_vld | output | 1 | Redirect pulse |
| redir_pc | output | 64 | New fetch PC |
| redir_npc | output | 64 | PC following redir_pc |
| saved_pc | output | 64 | Saved exception return address |
| shadow_enter | output | 1 | Switch to shadow register bank |
| shadow_exit | output | 1 | Leave shadow register bank |
| chk_intr | output | 1 | Recheck pending interrupts |
| arith_err | output | 1 | Unsupported arithmetic trap |

## Verification
The bench targets the shared handler entries. A table with a slip would send one of a pair of faults, such as fault 8 or 9, to the wrong handler. It checks the privileged-mode interrupt, where a design that always saves the PC would overwrite the return address of the handler already running. The skip of four bytes is checked on privileged calls and integer overflow and confirmed absent on ordinary faults, so an off-by-one-instruction return shows up. The bench also covers an illegal return from user mode, a fault that collides with a return request, and a vector base write in the same cycle as a trap, where a design with the wrong priority or a base forwarded too early lands on the wrong PC.

// File: rtl/trap_pkg.sv
// trap_pkg: shared fault encodings, save policies and lookup result type
// for the exception vector entry unit.
// Assumes fault codes are 5 bits wide and that codes above FC_INTOVF are unused.
package trap_pkg;

    localparam int FC_W  = 5;
    localparam int OFF_W = 16;

    typedef enum logic [FC_W-1:0] {
        FC_NONE     = 5'd0,
        FC_RESET    = 5'd1,
        FC_MCHK     = 5'd2,
        FC_ARITH    = 5'd3,
        FC_INTR     = 5'd4,
        FC_DTLB_NAT = 5'd5,
        FC_DTLB_PRV = 5'd6,
        FC_ALIGN    = 5'd7,
        FC_DFAULT   = 5'd8,
        FC_DACV     = 5'd9,
        FC_IMISS    = 5'd10,
        FC_IFAULT   = 5'd11,
        FC_IACV     = 5'd12,
        FC_UNIMP    = 5'd13,
        FC_FPDIS    = 5'd14,
        FC_PRIVCALL = 5'd15,
        FC_INTOVF   = 5'd16
    } fault_e;

    // How the saved return address reacts to a taken trap
    typedef enum logic [1:0] {
        SV_HOLD = 2'd0,
        SV_AT   = 2'd1,
        SV_PAST = 2'd2
    } save_e;

    typedef struct packed {
        logic             hit;
        logic [OFF_W-1:0] off;
        save_e            save;
        logic             err;
    } vec_info_t;

    // True for every code that names a real fault
    function automatic logic is_fault(input logic [FC_W-1:0] code);
        return (code != 5'd0) && (code <= 5'd16);
    endfunction

endpackage

// File: rtl/trap_vec_table.sv
// trap_vec_table: maps a fault code to its handler offset, save policy and
// error flag. Purely combinational.
// Assumes priv reflects bit 0 of the PC of the faulting instruction.
module trap_vec_table
    import trap_pkg::*;
(
    input  logic [FC_W-1:0] code,
    input  logic            priv,
    output vec_info_t       info
);

    // Decode the fault code into vector information
    always_comb begin
        info      = '0;
        info.save = SV_HOLD;
        info.hit  = 1'b1;
        info.save = SV_AT;
        case (code)
            FC_RESET:    info.off = 16'h0001;
            FC_MCHK:     info.off = 16'h0401;
            FC_INTR: begin
                info.off  = 16'h0101;
                info.save = priv ? SV_HOLD : SV_AT;
            end
            FC_DTLB_NAT: info.off = 16'h0201;
            FC_DTLB_PRV: info.off = 16'h0281;
            FC_ALIGN:    info.off = 16'h0301;
            FC_DFAULT,
            FC_DACV:     info.off = 16'h0381;
            FC_IMISS,
            FC_IFAULT:   info.off = 16'h0181;
            FC_IACV:     info.off = 16'h0081;
            FC_UNIMP:    info.off = 16'h0481;
            FC_FPDIS:    info.off = 16'h0581;
            FC_PRIVCALL: begin
                info.off  = 16'h2001;
                info.save = SV_PAST;
            end
            FC_INTOVF: begin
                info.off  = 16'h0501;
                info.save = SV_PAST;
            end
            FC_ARITH: begin
                info.hit  = 1'b0;
                info.save = SV_HOLD;
                info.err  = 1'b1;
            end
            default: begin
                info.hit  = 1'b0;
                info.save = SV_HOLD;
            end
        endcase
    end

endmodule

// File: rtl/trap_vbase_reg.sv
// trap_vbase_reg: holds the programmable vector base.
// Assumes a write takes effect at the clock edge that samples it.
module trap_vbase_reg #(
    parameter int               XLEN    = 64,
    parameter logic [XLEN-1:0]  RST_VAL = 64'h4000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] q
);

    // Load the base on reset or on a write
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_VAL;
        else if (we) q <= wdata;
    end

endmodule

// File: rtl/trap_save_reg.sv
// trap_save_reg: the saved exception return address register.
// Assumes upd is set only for a taken trap. The mode picks hold, current PC or PC+4.
module trap_save_reg
    import trap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd,
    input  save_e           mode,
    input  logic [XLEN-1:0] pc_in,
    output logic [XLEN-1:0] q
);

    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    // Capture the return address according to the save policy
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (upd) begin
            case (mode)
                SV_AT:   q <= pc_in;
                SV_PAST: q <= pc_in + INSN_BYTES;
                default: q <= q;
            endcase
        end
    end

    a_r5_skip_insn: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && mode == SV_PAST) |=> (q == $past(pc_in) + INSN_BYTES));

    a_r4_save_at: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && mode == SV_AT) |=> (q == $past(pc_in)));

endmodule

// File: rtl/trap_entry_unit.sv
// trap_entry_unit: trap entry and return-from-trap sequencer.
// Assumes one request per cycle. A fault takes priority over a return. All outputs
// are registered and pulse for one cycle after the sampling edge.
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int               XLEN      = 64,
    parameter logic [XLEN-1:0]  VBASE_RST = 64'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FC_W-1:0]   fault_code,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              rfe_req,
    input  logic              vb_we,
    input  logic [XLEN-1:0]   vb_wdata,
    output logic              redir_vld,
    output logic [XLEN-1:0]   redir_pc,
    output logic [XLEN-1:0]   redir_npc,
    output logic [XLEN-1:0]   saved_pc,
    output logic              shadow_enter,
    output logic              shadow_exit,
    output logic              chk_intr,
    output logic              arith_err
);

    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    logic              priv;
    logic              fault_act;
    logic              ret_ok;
    logic              ret_bad;
    logic              trap_go;
    logic              ret_go;
    logic [FC_W-1:0]   sel_code;
    vec_info_t         info;
    logic [XLEN-1:0]   vbase;
    logic [XLEN-1:0]   tgt_pc;

    assign priv      = cur_pc[0];
    assign fault_act = is_fault(fault_code);
    assign ret_ok    = rfe_req && priv;
    assign ret_bad   = rfe_req && !priv;

    // Choose the code to look up: a real fault, else an illegal return
    always_comb begin
        if (fault_act)    sel_code = fault_code;
        else if (ret_bad) sel_code = FC_UNIMP;
        else              sel_code = FC_NONE;
    end

    trap_vec_table u_table (
        .code (sel_code),
        .priv (priv),
        .info (info)
    );

    trap_vbase_reg #(.XLEN(XLEN), .RST_VAL(VBASE_RST)) u_vbase (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (vb_we),
        .wdata (vb_wdata),
        .q     (vbase)
    );

    assign trap_go = info.hit;
    assign ret_go  = !fault_act && ret_ok;

    trap_save_reg #(.XLEN(XLEN)) u_save (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (trap_go),
        .mode  (info.save),
        .pc_in (cur_pc),
        .q     (saved_pc)
    );

    // Redirect target: handler entry or saved return address
    always_comb begin
        if (trap_go)     tgt_pc = vbase + XLEN'(info.off);
        else if (ret_go) tgt_pc = saved_pc;
        else             tgt_pc = '0;
    end

    // Register the redirect and the one-cycle strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_vld    <= 1'b0;
            redir_pc     <= '0;
            redir_npc    <= '0;
            shadow_enter <= 1'b0;
            shadow_exit  <= 1'b0;
            chk_intr     <= 1'b0;
            arith_err    <= 1'b0;
        end else begin
            redir_vld    <= trap_go || ret_go;
            redir_pc     <= tgt_pc;
            redir_npc    <= (trap_go || ret_go) ? tgt_pc + INSN_BYTES : '0;
            shadow_enter <= trap_go && !priv;
            shadow_exit  <= ret_go && !saved_pc[0];
            chk_intr     <= ret_go;
            arith_err    <= info.err;
        end
    end

    a_r3_npc_follows: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld |-> (redir_npc == redir_pc + INSN_BYTES));

    a_r6_priv_intr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == FC_INTR && cur_pc[0]) |=> $stable(saved_pc));

    a_r7_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_enter |-> (redir_vld && !shadow_exit && !chk_intr));

    a_r8_chk_has_redir: assert property (@(posedge clk) disable iff (!rst_n)
        chk_intr |-> redir_vld);

    a_r10_arith_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        arith_err |-> (!redir_vld && !shadow_enter));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == FC_NONE && !rfe_req) |=> (!redir_vld && !arith_err && $stable(saved_pc)));

    a_r13_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (is_fault(fault_code) && rfe_req) |=> !chk_intr);

endmodule

// File: tb/tb_trap_entry_unit.sv
// tb_trap_entry_unit: table-driven check of trap entry and return, then
// directed tests for reset, vector base update and reset restart.
module tb_trap_entry_unit;

    localparam logic [63:0] VB = 64'h4000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  fault_code;
    logic [63:0] cur_pc;
    logic        rfe_req;
    logic        vb_we;
    logic [63:0] vb_wdata;
    logic        redir_vld;
    logic [63:0] redir_pc;
    logic [63:0] redir_npc;
    logic [63:0] saved_pc;
    logic        shadow_enter;
    logic        shadow_exit;
    logic        chk_intr;
    logic        arith_err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    trap_entry_unit #(.XLEN(64), .VBASE_RST(VB)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_code   (fault_code),
        .cur_pc       (cur_pc),
        .rfe_req      (rfe_req),
        .vb_we        (vb_we),
        .vb_wdata     (vb_wdata),
        .redir_vld    (redir_vld),
        .redir_pc     (redir_pc),
        .redir_npc    (redir_npc),
        .saved_pc     (saved_pc),
        .shadow_enter (shadow_enter),
        .shadow_exit  (shadow_exit),
        .chk_intr     (chk_intr),
        .arith_err    (arith_err)
    );

    // sv: 0 keep, 1 save pc, 2 save pc+4. isret: redirect to the model's saved pc.
    typedef struct packed {
        logic [4:0]  code;
        logic [63:0] pc;
        logic        rfe;
        logic        vld;
        logic        isret;
        logic [15:0] off;
        logic [1:0]  sv;
        logic        senter;
        logic        err;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{5'd1,  64'h1000, 1'b0, 1'b1, 1'b0, 16'h0001, 2'd1, 1'b1, 1'b0},
        '{5'd2,  64'h1004, 1'b0, 1'b1, 1'b0, 16'h0401, 2'd1, 1'b1, 1'b0},
        '{5'd4,  64'h2000, 1'b0, 1'b1, 1'b0, 16'h0101, 2'd1, 1'b1, 1'b0},
        '{5'd4,  64'h4101, 1'b0, 1'b1, 1'b0, 16'h0101, 2'd0, 1'b0, 1'b0},
        '{5'd5,  64'h3000, 1'b0, 1'b1, 1'b0, 16'h0201, 2'd1, 1'b1, 1'b0},
        '{5'd6,  64'h3004, 1'b0, 1'b1, 1'b0, 16'h0281, 2'd1, 1'b1, 1'b0},
        '{5'd7,  64'h3008, 1'b0, 1'b1, 1'b0, 16'h0301, 2'd1, 1'b1, 1'b0},
        '{5'd8,  64'h300c, 1'b0, 1'b1, 1'b0, 16'h0381, 2'd1, 1'b1, 1'b0},
        '{5'd9,  64'h3010, 1'b0, 1'b1, 1'b0, 16'h0381, 2'd1, 1'b1, 1'b0},
        '{5'd10, 64'h3014, 1'b0, 1'b1, 1'b0, 16'h0181, 2'd1, 1'b1, 1'b0},
        '{5'd11, 64'h3018, 1'b0, 1'b1, 1'b0, 16'h0181, 2'd1, 1'b1, 1'b0},
        '{5'd12, 64'h301c, 1'b0, 1'b1, 1'b0, 16'h0081, 2'd1, 1'b1, 1'b0},
        '{5'd13, 64'h3020, 1'b0, 1'b1, 1'b0, 16'h0481, 2'd1, 1'b1, 1'b0},
        '{5'd14, 64'h3024, 1'b0, 1'b1, 1'b0, 16'h0581, 2'd1, 1'b1, 1'b0},
        '{5'd15, 64'h3028, 1'b0, 1'b1, 1'b0, 16'h2001, 2'd2, 1'b1, 1'b0},
        '{5'd0,  64'h6001, 1'b1, 1'b1, 1'b1, 16'h0000, 2'd0, 1'b0, 1'b0},
        '{5'd16, 64'h5000, 1'b0, 1'b1, 1'b0, 16'h0501, 2'd2, 1'b1, 1'b0},
        '{5'd3,  64'h7000, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd0, 1'b0, 1'b1},
        '{5'd0,  64'h7004, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd0, 1'b0, 1'b0},
        '{5'd20, 64'h7008, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd0, 1'b0, 1'b0},
        '{5'd5,  64'h4201, 1'b0, 1'b1, 1'b0, 16'h0201, 2'd1, 1'b0, 1'b0},
        '{5'd0,  64'h4301, 1'b1, 1'b1, 1'b1, 16'h0000, 2'd0, 1'b0, 1'b0},
        '{5'd0,  64'h8000, 1'b1, 1'b1, 1'b0, 16'h0481, 2'd1, 1'b1, 1'b0},
        '{5'd7,  64'h9000, 1'b1, 1'b1, 1'b0, 16'h0301, 2'd1, 1'b1, 1'b0}
    };

    // Compare one value and record the result
    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Return inputs to idle
    task automatic idle();
        fault_code = 5'd0;
        cur_pc     = 64'h0;
        rfe_req    = 1'b0;
        vb_we      = 1'b0;
        vb_wdata   = 64'h0;
    endtask

    // Apply the current inputs for one edge, then sample at the following negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    logic [63:0] m_saved;
    logic [63:0] e_pc;

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 redir_vld", 64'(redir_vld), 64'd0);
        check("R1 saved_pc", saved_pc, 64'd0);
        check("R1 strobes", {60'd0, shadow_enter, shadow_exit, chk_intr, arith_err}, 64'd0);
        rst_n = 1'b1;
        step();
        check("R11 idle after reset", 64'(redir_vld), 64'd0);

        m_saved = 64'h0;
        // R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R13: table walk
        for (int i = 0; i < NV; i++) begin
            fault_code = VECS[i].code;
            cur_pc     = VECS[i].pc;
            rfe_req    = VECS[i].rfe;
            e_pc = VECS[i].isret ? m_saved : VB + 64'(VECS[i].off);
            step();
            check($sformatf("R3 vld v%0d", i), 64'(redir_vld), 64'(VECS[i].vld));
            if (VECS[i].vld) begin
                check($sformatf("R2 pc v%0d", i), redir_pc, e_pc);
                check($sformatf("R3 npc v%0d", i), redir_npc, e_pc + 64'd4);
            end
            check($sformatf("R8 exit v%0d", i), 64'(shadow_exit),
                  64'(VECS[i].isret && !m_saved[0]));
            check($sformatf("R8 R13 chk v%0d", i), 64'(chk_intr), 64'(VECS[i].isret));
            check($sformatf("R7 enter v%0d", i), 64'(shadow_enter), 64'(VECS[i].senter));
            check($sformatf("R10 err v%0d", i), 64'(arith_err), 64'(VECS[i].err));
            if (VECS[i].sv == 2'd1) m_saved = VECS[i].pc;
            else if (VECS[i].sv == 2'd2) m_saved = VECS[i].pc + 64'd4;
            check($sformatf("R4 R5 R6 saved v%0d", i), saved_pc, m_saved);
            idle();
            step();
            check($sformatf("R3 pulse v%0d", i), 64'(redir_vld), 64'd0);
        end

        // R12: base write in the same cycle as a trap uses the old base
        fault_code = 5'd13;
        cur_pc     = 64'h100;
        vb_we      = 1'b1;
        vb_wdata   = 64'h10000;
        step();
        check("R12 old base", redir_pc, VB + 64'h481);
        idle();
        fault_code = 5'd13;
        cur_pc     = 64'h104;
        step();
        check("R12 new base", redir_pc, 64'h10481);
        idle();

        // R1: reset restores the base constant
        rst_n = 1'b0;
        step();
        check("R1 saved after reset", saved_pc, 64'd0);
        rst_n = 1'b1;
        fault_code = 5'd1;
        cur_pc     = 64'h200;
        step();
        check("R1 base restored", redir_pc, VB + 64'h1);
        idle();
        step();

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule